// File: doc/BRIEF.md
# DMA Page Register File and Transfer Address Former

This block holds the page bytes that extend a DMA controller's 16-bit channel addresses into a wide physical address, and forms the start address of each memory block that a channel moves. Software reaches the page bytes through an eight-slot port window. Only four slots in that window are wired to channels, and the wiring is scattered. A second bank of high page bytes can be left out of the build with a parameter.

At the start of a block, the controller gives the channel number, the channel's current 16-bit address, its mode byte, the position of the block within the transfer, and the block length. One clock later the block drives a 31-bit start address with a valid pulse. It also drives a flag that tells the memory side to present the block's bytes in reversed order. In increment mode the block starts at the formed address plus the position. In decrement mode it starts at the far end: the formed address minus the position minus the length.

Top module: `dma_page_addr`

## Requirements
- R1: After reset every low and high page byte reads as 0, `xfer_valid` is 0 and `xfer_addr` is 0.
- R2: Port window slot 7 selects channel 0, slot 3 selects channel 1, slot 1 selects channel 2 and slot 2 selects channel 3, for both reads and writes of the page bytes.
- R3: Slots 0, 4, 5 and 6 are unmapped. Writes to them change no page byte, and reads from them return 0.
- R4: The low bank (`pg_sel_high`=0) and the high bank (`pg_sel_high`=1) are separate. A read with `pg_rd_en`=1 returns, in the same cycle, the full 8-bit byte last written to that bank and channel. With `pg_rd_en`=0, `pg_rdata` is 0.
- R5: With `HIGH_PAGE_EN`=0, high bank reads return 0, high bank writes are ignored, and address bits 30:24 are those of a zero high page.
- R6: The formed address is {high page bits 6:0, low page byte, current address} in bits 30:24, 23:16 and 15:0. High page bit 7 has no effect.
- R7: When `xfer_mode` bit 5 is 0 (increment), the start address is formed address + `xfer_pos`, taken modulo 2^31, and `xfer_reverse` is 0. All other mode bits have no effect.
- R8: When `xfer_mode` bit 5 is 1 (decrement), the start address is formed address − `xfer_pos` − `xfer_len`, taken modulo 2^31, and `xfer_reverse` is 1.
- R9: `xfer_valid` is high for exactly the one cycle that follows a cycle with `xfer_start`=1. `xfer_addr` and `xfer_reverse` hold their values until the next start.
- R10: A start in the same cycle as a page write to that channel uses the page value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pg_wr_en | input | 1 | Page byte write strobe |
| pg_rd_en | input | 1 | Page byte read enable |
| pg_sel_high | input | 1 | 0 selects the low bank, 1 selects the high bank |
| pg_slot | input | 3 | Port window slot |
| pg_wdata | input | 8 | Write data |
| pg_rdata | output | 8 | Combinational read data |
| xfer_start | input | 1 | Start strobe for address forming |
| xfer_chan | input | 2 | Channel number of the block |
| xfer_cur_addr | input | 16 | Channel current address |
| xfer_mode | input | 8 | Channel mode byte; bit 5 selects decrement |
| xfer_pos | input | 16 | Block position within the transfer |
| xfer_len | input | 16 | Block length |
| xfer_addr | output | 31 | Registered start address |
| xfer_valid | output | 1 | One-cycle pulse when `xfer_addr` is new |
| xfer_reverse | output | 1 | Registered reverse-order flag |

## Verification
The hardest situation to reach is the wrap of the 31-bit sum past either end of the physical space. A decrement block must underflow below address zero, and an increment block must overflow past a full page. The bench reaches both on purpose. It loads all-zero and all-ones page bytes through their scattered slots, then sweeps the position and length through 0, 1, mid-range and maximum values for every channel in both directions. A second instance built without the high bank takes the same stimulus, so that each sweep also checks the high bank being dropped. A start in the same cycle as a write to that channel's page byte is driven on its own to show which page value the start uses.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned CH_W     = 2;
  localparam int unsigned SLOT_W   = 3;
  localparam int unsigned MODE_DIR_BIT = 5;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] chan;
  } slot_route_t;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;

  // Scattered slot-to-channel wiring of the page window.
  function automatic slot_route_t route_slot(input logic [SLOT_W-1:0] slot);
    slot_route_t r;
    r.hit  = 1'b1;
    r.chan = '0;
    case (slot)
      3'd7:    r.chan = 2'd0;
      3'd3:    r.chan = 2'd1;
      3'd1:    r.chan = 2'd2;
      3'd2:    r.chan = 2'd3;
      default: r.hit  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
  import dma_page_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  output logic              hit,
  output logic [CH_W-1:0]   chan
);
  slot_route_t route;

  always_comb begin
    route = route_slot(slot);
    hit   = route.hit;
    chan  = route.chan;
  end
endmodule

// File: rtl/dma_page_regfile.sv
module dma_page_regfile
  import dma_page_pkg::*;
#(
  parameter int unsigned PAGE_W  = 8,
  parameter bit          HIGH_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     sel_high,
  input  logic                     hit,
  input  logic [CH_W-1:0]          chan,
  input  logic [PAGE_W-1:0]        wdata,
  output logic [PAGE_W-1:0]        rdata,
  output logic [NUM_CH*PAGE_W-1:0] lo_flat,
  output logic [NUM_CH*PAGE_W-1:0] hi_flat
);
  localparam int unsigned FLAT_W = NUM_CH * PAGE_W;

  logic [NUM_CH-1:0] lo_we;
  logic [NUM_CH-1:0] hi_we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign lo_we[c] = wr_en && hit && !sel_high && (chan == CH_W'(c));
    assign hi_we[c] = wr_en && hit &&  sel_high && (chan == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lo_flat[c*PAGE_W +: PAGE_W] <= '0;
      else if (lo_we[c]) lo_flat[c*PAGE_W +: PAGE_W] <= wdata;
    end

    if (HIGH_EN) begin : g_high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_flat[c*PAGE_W +: PAGE_W] <= '0;
        else if (hi_we[c]) hi_flat[c*PAGE_W +: PAGE_W] <= wdata;
      end
    end else begin : g_no_high
      assign hi_flat[c*PAGE_W +: PAGE_W] = '0;
    end
  end

  logic [FLAT_W-1:0] bank_sel;
  assign bank_sel = sel_high ? hi_flat : lo_flat;

  always_comb begin
    rdata = '0;
    if (rd_en && hit) rdata = bank_sel[chan*PAGE_W +: PAGE_W];
  end
endmodule

// File: rtl/dma_addr_former.sv
module dma_addr_former
  import dma_page_pkg::*;
#(
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned HI_USE  = 7,
  parameter int unsigned CUR_W   = 16,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned PHYS_W = HI_USE + PAGE_W + CUR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CH_W-1:0]          chan,
  input  logic [CUR_W-1:0]         cur_addr,
  input  step_dir_e                dir,
  input  logic [LEN_W-1:0]         pos,
  input  logic [LEN_W-1:0]         len,
  input  logic [NUM_CH*PAGE_W-1:0] lo_flat,
  input  logic [NUM_CH*PAGE_W-1:0] hi_flat,
  output logic [PHYS_W-1:0]        addr,
  output logic                     valid,
  output logic                     reverse
);
  function automatic logic [PHYS_W-1:0] join_phys(
    input logic [PAGE_W-1:0] hi,
    input logic [PAGE_W-1:0] lo,
    input logic [CUR_W-1:0]  cur
  );
    return {hi[HI_USE-1:0], lo, cur};
  endfunction

  function automatic logic [PHYS_W-1:0] block_start(
    input logic [PHYS_W-1:0] base,
    input step_dir_e         d,
    input logic [LEN_W-1:0]  p,
    input logic [LEN_W-1:0]  l
  );
    if (d == DIR_DOWN) return base - PHYS_W'(p) - PHYS_W'(l);
    return base + PHYS_W'(p);
  endfunction

  logic [PAGE_W-1:0] sel_lo, sel_hi;
  logic [PHYS_W-1:0] phys_base, next_addr;

  assign sel_lo    = lo_flat[chan*PAGE_W +: PAGE_W];
  assign sel_hi    = hi_flat[chan*PAGE_W +: PAGE_W];
  assign phys_base = join_phys(sel_hi, sel_lo, cur_addr);
  assign next_addr = block_start(phys_base, dir, pos, len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      valid   <= 1'b0;
      reverse <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        addr    <= next_addr;
        reverse <= (dir == DIR_DOWN);
      end
    end
  end
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
  import dma_page_pkg::*;
#(
  parameter bit          HIGH_PAGE_EN = 1'b1,
  parameter int unsigned PAGE_W       = 8,
  parameter int unsigned HI_USE       = 7,
  parameter int unsigned CUR_W        = 16,
  parameter int unsigned LEN_W        = 16,
  localparam int unsigned PHYS_W      = HI_USE + PAGE_W + CUR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_wr_en,
  input  logic              pg_rd_en,
  input  logic              pg_sel_high,
  input  logic [2:0]        pg_slot,
  input  logic [PAGE_W-1:0] pg_wdata,
  output logic [PAGE_W-1:0] pg_rdata,
  input  logic              xfer_start,
  input  logic [1:0]        xfer_chan,
  input  logic [CUR_W-1:0]  xfer_cur_addr,
  input  logic [7:0]        xfer_mode,
  input  logic [LEN_W-1:0]  xfer_pos,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic [PHYS_W-1:0] xfer_addr,
  output logic              xfer_valid,
  output logic              xfer_reverse
);
  logic                     slot_hit;
  logic [CH_W-1:0]          slot_chan;
  logic [NUM_CH*PAGE_W-1:0] lo_flat;
  logic [NUM_CH*PAGE_W-1:0] hi_flat;
  step_dir_e                step_dir;

  assign step_dir = step_dir_e'(xfer_mode[MODE_DIR_BIT]);

  dma_page_decode u_decode (
    .slot (pg_slot),
    .hit  (slot_hit),
    .chan (slot_chan)
  );

  dma_page_regfile #(
    .PAGE_W  (PAGE_W),
    .HIGH_EN (HIGH_PAGE_EN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pg_wr_en),
    .rd_en    (pg_rd_en),
    .sel_high (pg_sel_high),
    .hit      (slot_hit),
    .chan     (slot_chan),
    .wdata    (pg_wdata),
    .rdata    (pg_rdata),
    .lo_flat  (lo_flat),
    .hi_flat  (hi_flat)
  );

  dma_addr_former #(
    .PAGE_W (PAGE_W),
    .HI_USE (HI_USE),
    .CUR_W  (CUR_W),
    .LEN_W  (LEN_W)
  ) u_former (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (xfer_start),
    .chan     (xfer_chan),
    .cur_addr (xfer_cur_addr),
    .dir      (step_dir),
    .pos      (xfer_pos),
    .len      (xfer_len),
    .lo_flat  (lo_flat),
    .hi_flat  (hi_flat),
    .addr     (xfer_addr),
    .valid    (xfer_valid),
    .reverse  (xfer_reverse)
  );
endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk #(
  parameter bit          HIGH_EN = 1'b1,
  parameter int unsigned FLAT_W  = 32,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned PHYS_W  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_wr_en,
  input logic              pg_rd_en,
  input logic              pg_sel_high,
  input logic              slot_hit,
  input logic [PAGE_W-1:0] pg_rdata,
  input logic [FLAT_W-1:0] lo_flat,
  input logic [FLAT_W-1:0] hi_flat,
  input logic              xfer_start,
  input logic              mode_down,
  input logic              xfer_valid,
  input logic [PHYS_W-1:0] xfer_addr,
  input logic              xfer_reverse
);
  a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> xfer_valid);

  a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |=> !xfer_valid);

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |=> ($stable(xfer_addr) && $stable(xfer_reverse)));

  a_r8_reverse_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (xfer_reverse == $past(mode_down)));

  a_r3_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rd_en && !slot_hit) |-> (pg_rdata == '0));

  a_r3_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr_en && !slot_hit) |=> ($stable(lo_flat) && $stable(hi_flat)));

  a_r5_no_high_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!HIGH_EN && pg_rd_en && pg_sel_high) |-> (pg_rdata == '0));
endmodule

bind dma_page_addr dma_page_addr_chk #(
  .HIGH_EN (HIGH_PAGE_EN),
  .FLAT_W  (4 * PAGE_W),
  .PAGE_W  (PAGE_W),
  .PHYS_W  (PHYS_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pg_wr_en     (pg_wr_en),
  .pg_rd_en     (pg_rd_en),
  .pg_sel_high  (pg_sel_high),
  .slot_hit     (slot_hit),
  .pg_rdata     (pg_rdata),
  .lo_flat      (lo_flat),
  .hi_flat      (hi_flat),
  .xfer_start   (xfer_start),
  .mode_down    (xfer_mode[5]),
  .xfer_valid   (xfer_valid),
  .xfer_addr    (xfer_addr),
  .xfer_reverse (xfer_reverse)
);

// File: tb/dma_page_addr_tb_top.sv
module dma_page_addr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_wr_en = 1'b0, pg_rd_en = 1'b0, pg_sel_high = 1'b0;
  logic [2:0]  pg_slot = '0;
  logic [7:0]  pg_wdata = '0;
  logic [7:0]  rdata_a, rdata_b;
  logic        xfer_start = 1'b0;
  logic [1:0]  xfer_chan = '0;
  logic [15:0] xfer_cur_addr = '0;
  logic [7:0]  xfer_mode = '0;
  logic [15:0] xfer_pos = '0, xfer_len = '0;
  logic [30:0] addr_a, addr_b;
  logic        valid_a, valid_b, rev_a, rev_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the page bytes.
  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];

  always #2 clk = ~clk;

  dma_page_addr #(.HIGH_PAGE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_rd_en(pg_rd_en),
    .pg_sel_high(pg_sel_high), .pg_slot(pg_slot), .pg_wdata(pg_wdata),
    .pg_rdata(rdata_a), .xfer_start(xfer_start), .xfer_chan(xfer_chan),
    .xfer_cur_addr(xfer_cur_addr), .xfer_mode(xfer_mode), .xfer_pos(xfer_pos),
    .xfer_len(xfer_len), .xfer_addr(addr_a), .xfer_valid(valid_a),
    .xfer_reverse(rev_a));

  dma_page_addr #(.HIGH_PAGE_EN(1'b0)) dut_nohi_i (
    .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_rd_en(pg_rd_en),
    .pg_sel_high(pg_sel_high), .pg_slot(pg_slot), .pg_wdata(pg_wdata),
    .pg_rdata(rdata_b), .xfer_start(xfer_start), .xfer_chan(xfer_chan),
    .xfer_cur_addr(xfer_cur_addr), .xfer_mode(xfer_mode), .xfer_pos(xfer_pos),
    .xfer_len(xfer_len), .xfer_addr(addr_b), .xfer_valid(valid_b),
    .xfer_reverse(rev_b));

  function automatic int slot_to_ch(input int s);
    case (s)
      7: return 0;
      3: return 1;
      1: return 2;
      2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int ch_to_slot(input int c);
    case (c)
      0: return 7;
      1: return 3;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic longint expect_addr(input longint hi, input longint lo,
      input longint cur, input bit down, input longint p, input longint l);
    longint base, r;
    base = (hi % 128) * 64'd16777216 + lo * 64'd65536 + cur;
    r = down ? (base - p - l) : (base + p);
    return r & 64'h7FFF_FFFF;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic page_write(input bit high, input int s, input logic [7:0] d);
    @(negedge clk);
    pg_wr_en = 1'b1; pg_sel_high = high; pg_slot = 3'(s); pg_wdata = d;
    @(negedge clk);
    pg_wr_en = 1'b0;
    if (slot_to_ch(s) >= 0) begin
      if (high) m_hi[slot_to_ch(s)] = d;
      else      m_lo[slot_to_ch(s)] = d;
    end
  endtask

  task automatic page_read(input bit high, input int s, input string req);
    int c;
    logic [7:0] ea, eb;
    @(negedge clk);
    pg_rd_en = 1'b1; pg_sel_high = high; pg_slot = 3'(s);
    #1;
    c = slot_to_ch(s);
    ea = (c < 0) ? 8'h00 : (high ? m_hi[c] : m_lo[c]);
    eb = (c < 0 || high) ? 8'h00 : m_lo[c];
    check(req, rdata_a, ea);
    check({req, " nohigh"}, rdata_b, eb);
    pg_rd_en = 1'b0;
  endtask

  task automatic run_xfer(input int c, input logic [15:0] cur, input bit down,
      input logic [15:0] p, input logic [15:0] l, input string req);
    @(negedge clk);
    xfer_start = 1'b1; xfer_chan = 2'(c); xfer_cur_addr = cur;
    xfer_mode = down ? 8'hF5 : 8'hCA;  // only bit 5 matters
    xfer_pos = p; xfer_len = l;
    @(negedge clk);
    xfer_start = 1'b0;
    check({req, " valid R9"}, valid_a, 1);
    check(req, addr_a, expect_addr(m_hi[c], m_lo[c], cur, down, p, l));
    check({req, " R5 nohigh"}, addr_b, expect_addr(0, m_lo[c], cur, down, p, l));
    check({req, " reverse"}, rev_a, down);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] vals [4];
    logic [30:0] held;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'hFFFF;
    for (int c = 0; c < 4; c++) begin m_lo[c] = '0; m_hi[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 valid", valid_a, 0);
    check("R1 addr", addr_a, 0);
    for (int s = 0; s < 8; s++) begin
      page_read(1'b0, s, "R1 low reset");
      page_read(1'b1, s, "R1 high reset");
    end

    // R2 R3 R4: write every slot of both banks, read all back
    for (int s = 0; s < 8; s++) begin
      page_write(1'b0, s, 8'(8'h10 + s * 8'h11));
      page_write(1'b1, s, 8'(8'h80 + s * 8'h05));
    end
    for (int s = 0; s < 8; s++) begin
      page_read(1'b0, s, (slot_to_ch(s) < 0) ? "R3 low unmapped" : "R2 R4 low");
      page_read(1'b1, s, (slot_to_ch(s) < 0) ? "R3 high unmapped" : "R2 R4 high R5");
    end
    // R4: read enable low gives 0
    @(negedge clk);
    pg_rd_en = 1'b0; pg_slot = 3'd7; #1;
    check("R4 rd_en low", rdata_a, 0);

    // R6 R7 R8: sweep every channel, direction, position and length
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            run_xfer(c, 16'(16'h1234 * (c + 1)), d[0], vals[i], vals[j],
                     d ? "R8 R6 down" : "R7 R6 up");

    // Wrap corners: zero pages underflow, all-ones pages overflow
    page_write(1'b0, ch_to_slot(0), 8'h00);
    page_write(1'b1, ch_to_slot(0), 8'h00);
    page_write(1'b0, ch_to_slot(1), 8'hFF);
    page_write(1'b1, ch_to_slot(1), 8'hFF);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        run_xfer(0, 16'h0000, 1'b1, vals[i], vals[j], "R8 underflow");
        run_xfer(1, 16'hFFFF, 1'b0, vals[i], vals[j], "R7 overflow");
      end

    // R9: valid drops and address holds with no start
    held = addr_a;
    @(negedge clk);
    xfer_cur_addr = 16'hABCD; xfer_pos = 16'h0042;
    @(negedge clk);
    check("R9 valid low", valid_a, 0);
    check("R9 addr held", addr_a, held);
    check("R9 reverse held", rev_a, 0);

    // R10: start in the same cycle as a page write uses the old page
    @(negedge clk);
    pg_wr_en = 1'b1; pg_sel_high = 1'b0; pg_slot = 3'(ch_to_slot(2)); pg_wdata = 8'h5A;
    xfer_start = 1'b1; xfer_chan = 2'd2; xfer_cur_addr = 16'h0100;
    xfer_mode = 8'h00; xfer_pos = 16'h0003; xfer_len = 16'h0000;
    @(negedge clk);
    pg_wr_en = 1'b0; xfer_start = 1'b0;
    check("R10 old page", addr_a, expect_addr(m_hi[2], m_lo[2], 16'h0100, 1'b0, 3, 0));
    m_lo[2] = 8'h5A;
    run_xfer(2, 16'h0100, 1'b0, 16'h0003, 16'h0000, "R10 new page");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule